// File: doc/BRIEF.md
# Row-Organised Nibble RAM with Bus Snooping

This block is a small data memory that shares a 4-bit multiplexed bus with a 4-bit processor. It stores 320 bits as 20 rows of 16 bits. Each row is split into four 4-bit lanes. The array never touches a single lane directly. Every access reads or writes a whole row, and a lane multiplexer picks one nibble out of the row or merges one nibble back into it.

The block has no read or write strobe. It follows the processor's instruction stream on the shared bus. In the first fetch phase it records the opcode nibble. In the second fetch phase it decodes the operand nibble. From these two it knows whether the coming execute phase reads it, writes it, or loads a new row and lane selection.

- On a read, the selected row is copied into a row buffer during the second fetch phase, and the chosen nibble is driven onto the bus during execute.
- On a write, the nibble on the bus is merged into the buffered row, and the full row is written back.
- In every cycle without an access, a refresh pointer rewrites one row with its own contents and then steps to the next row.

The bus is modelled as separate `bus_i`, `bus_o` and `bus_oe_o` pins. `bus_oe_o` is the drive enable of an external tri-state buffer.

Top module: `nibble_row_ram`

## Requirements
- R1: While reset is asserted and after it is released, `bus_oe_o` is 0. The selection is cleared to row 0, lane 0, so an access made before any select instruction goes to row 0, lane 0.
- R2: An instruction whose opcode nibble (captured with `fetch_hi_i`) is 4'hE is a memory access. The operand nibble (captured with `fetch_lo_i`) sets its direction: bit 3 = 1 means read, bit 3 = 0 means write.
- R3: During the single `exec_i` cycle of a read, `bus_oe_o` is 1 and `bus_o` holds the selected nibble. In every other cycle, including the fetch phases of that read, `bus_oe_o` is 0.
- R4: A write replaces only the selected 4-bit lane of the selected row, taking the value on `bus_i` in its `exec_i` cycle. The other three lanes of that row keep their values.
- R5: Opcode 4'h2 is a select instruction with two consecutive `exec_i` beats. In the first beat, bits [2:1] give the lane (lane k occupies row bits [4k+3:4k]) and bit 0 gives row bit 4. In the second beat, bits [3:0] give row bits [3:0]. The selection is then held until the next select instruction.
- R6: A select instruction that names a row of 20 or above is ignored. Both the row and the lane stay as they were.
- R7: An instruction with any opcode other than 4'hE or 4'h2 does not drive the bus and changes no stored data.
- R8: In every cycle that neither loads a row for an access nor writes one back, the refresh pointer rewrites its row unchanged and advances, wrapping from row 19 to row 0. Stored data survives any number of idle cycles.
- R9: Rows are independent. A write to one row leaves every other row unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_hi_i | input | 1 | First fetch phase valid; the opcode nibble is on the bus |
| fetch_lo_i | input | 1 | Second fetch phase valid; the operand nibble is on the bus |
| exec_i | input | 1 | Execute phase valid; a data or select nibble is on the bus |
| bus_i | input | 4 | Shared bus, value seen at the pins |
| bus_o | output | 4 | Nibble driven toward the bus |
| bus_oe_o | output | 1 | Drive enable for `bus_o` |

## Verification
Some properties are checked by assertions on every cycle:
- the bus is driven only inside an execute phase;
- the selected row and the refresh pointer always stay below 20;
- the selection changes only on an execute beat;
- the refresh pointer steps by one, wrapping at 19, after each idle cycle.

Other behaviour can only be shown by the bench's instruction sequences:
- that a write leaves the neighbouring lanes and the other rows intact;
- that an out-of-range select is ignored;
- that an unrelated opcode neither drives the bus nor disturbs the data;
- that refresh keeps the contents through long idle stretches.

// File: rtl/nram_pkg.sv
package nram_pkg;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned LANES   = 4;
  localparam int unsigned ROW_BITS = NIB_W * LANES;
  localparam int unsigned ROW_AW  = 5;   // fixed by the two-beat select encoding
  localparam int unsigned LANE_AW = $clog2(LANES);

  localparam logic [NIB_W-1:0] OP_MEM = 4'hE;
  localparam logic [NIB_W-1:0] OP_SEL = 4'h2;

  typedef enum logic [2:0] {
    MD_IDLE,
    MD_READ,
    MD_WRITE,
    MD_SEL1,
    MD_SEL2
  } mode_e;
endpackage

// File: rtl/nram_decoder.sv
module nram_decoder
  import nram_pkg::*;
#(
  parameter int unsigned ROWS = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_hi_i,
  input  logic               fetch_lo_i,
  input  logic               exec_i,
  input  logic [NIB_W-1:0]   bus_i,
  output logic               row_load_o,
  output logic               acc_rd_o,
  output logic               acc_wr_o,
  output logic [ROW_AW-1:0]  sel_row_o,
  output logic [LANE_AW-1:0] sel_lane_o
);
  logic [NIB_W-1:0]   opc_q;
  mode_e              mode_q;
  logic [2:0]         beat_q;
  logic [ROW_AW-1:0]  sel_row_q;
  logic [LANE_AW-1:0] sel_lane_q;
  logic [ROW_AW-1:0]  row_cand;

  assign row_cand = {beat_q[0], bus_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q      <= '0;
      mode_q     <= MD_IDLE;
      beat_q     <= '0;
      sel_row_q  <= '0;
      sel_lane_q <= '0;
    end else if (fetch_hi_i) begin
      opc_q  <= bus_i;
      mode_q <= MD_IDLE;
    end else if (fetch_lo_i) begin
      if (opc_q == OP_MEM)      mode_q <= bus_i[3] ? MD_READ : MD_WRITE;
      else if (opc_q == OP_SEL) mode_q <= MD_SEL1;
      else                      mode_q <= MD_IDLE;
    end else if (exec_i) begin
      case (mode_q)
        MD_SEL1: begin
          beat_q <= bus_i[2:0];
          mode_q <= MD_SEL2;
        end
        MD_SEL2: begin
          if (int'(row_cand) < int'(ROWS)) begin
            sel_row_q  <= row_cand;
            sel_lane_q <= beat_q[2:1];
          end
          mode_q <= MD_IDLE;
        end
        default: mode_q <= MD_IDLE;
      endcase
    end
  end

  assign row_load_o = fetch_lo_i && (opc_q == OP_MEM);
  assign acc_rd_o   = exec_i && !fetch_hi_i && !fetch_lo_i && (mode_q == MD_READ);
  assign acc_wr_o   = exec_i && !fetch_hi_i && !fetch_lo_i && (mode_q == MD_WRITE);
  assign sel_row_o  = sel_row_q;
  assign sel_lane_o = sel_lane_q;

  AST_SEL_ROW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(sel_row_q) < int'(ROWS)); // R6

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(exec_i) |-> ($stable(sel_row_q) && $stable(sel_lane_q))); // R5
endmodule

// File: rtl/nram_array.sv
module nram_array
  import nram_pkg::*;
#(
  parameter int unsigned ROWS = 20
) (
  input  logic                clk_i,
  input  logic [ROW_AW-1:0]   rd_a_row_i,
  output logic [ROW_BITS-1:0] rd_a_data_o,
  input  logic [ROW_AW-1:0]   rd_b_row_i,
  output logic [ROW_BITS-1:0] rd_b_data_o,
  input  logic                we_i,
  input  logic [ROW_AW-1:0]   wr_row_i,
  input  logic [ROW_BITS-1:0] wr_data_i
);
  logic [ROW_BITS-1:0] cells [ROWS];

  assign rd_a_data_o = cells[rd_a_row_i];
  assign rd_b_data_o = cells[rd_b_row_i];

  always_ff @(posedge clk_i) begin
    if (we_i) cells[wr_row_i] <= wr_data_i;
  end
endmodule

// File: rtl/nram_lane_mux.sv
module nram_lane_mux
  import nram_pkg::*;
(
  input  logic [ROW_BITS-1:0] row_i,
  input  logic [LANE_AW-1:0]  lane_i,
  input  logic [NIB_W-1:0]    nib_i,
  output logic [NIB_W-1:0]    nib_o,
  output logic [ROW_BITS-1:0] merged_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged_o[l*NIB_W +: NIB_W] =
      (lane_i == LANE_AW'(l)) ? nib_i : row_i[l*NIB_W +: NIB_W];
  end

  assign nib_o = row_i[lane_i*NIB_W +: NIB_W];
endmodule

// File: rtl/nram_refresh.sv
module nram_refresh
  import nram_pkg::*;
#(
  parameter int unsigned ROWS = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [ROW_AW-1:0] ptr_o
);
  localparam logic [ROW_AW-1:0] LAST = ROW_AW'(ROWS - 1);

  logic [ROW_AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  AST_REF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ptr_q) < int'(ROWS)); // R8

  AST_REF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1))); // R8
endmodule

// File: rtl/nibble_row_ram.sv
module nibble_row_ram
  import nram_pkg::*;
#(
  parameter int unsigned ROWS = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fetch_hi_i,
  input  logic       fetch_lo_i,
  input  logic       exec_i,
  input  logic [3:0] bus_i,
  output logic [3:0] bus_o,
  output logic       bus_oe_o
);
  logic                row_load, acc_rd, acc_wr, ref_adv;
  logic [ROW_AW-1:0]   sel_row, ref_row, wr_row;
  logic [LANE_AW-1:0]  sel_lane;
  logic [ROW_BITS-1:0] sel_data, ref_data, wr_data, merged, row_buf_q;
  logic [NIB_W-1:0]    rd_nib;

  nram_decoder #(.ROWS(ROWS)) u_dec (
    .clk_i, .rst_ni, .fetch_hi_i, .fetch_lo_i, .exec_i, .bus_i,
    .row_load_o(row_load), .acc_rd_o(acc_rd), .acc_wr_o(acc_wr),
    .sel_row_o(sel_row), .sel_lane_o(sel_lane)
  );

  // refresh owns the write port whenever no access is in flight
  assign ref_adv = !(row_load || acc_wr);
  assign wr_row  = acc_wr ? sel_row : ref_row;
  assign wr_data = acc_wr ? merged  : ref_data;

  nram_refresh #(.ROWS(ROWS)) u_ref (
    .clk_i, .rst_ni, .adv_i(ref_adv), .ptr_o(ref_row)
  );

  nram_array #(.ROWS(ROWS)) u_arr (
    .clk_i,
    .rd_a_row_i(sel_row), .rd_a_data_o(sel_data),
    .rd_b_row_i(ref_row), .rd_b_data_o(ref_data),
    .we_i(1'b1), .wr_row_i(wr_row), .wr_data_i(wr_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       row_buf_q <= '0;
    else if (row_load) row_buf_q <= sel_data;
  end

  nram_lane_mux u_mux (
    .row_i(row_buf_q), .lane_i(sel_lane), .nib_i(bus_i),
    .nib_o(rd_nib), .merged_o(merged)
  );

  assign bus_oe_o = acc_rd;
  assign bus_o    = acc_rd ? rd_nib : '0;

  AST_OE_ONLY_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (exec_i && !fetch_hi_i && !fetch_lo_i)); // R3

  AST_NO_RD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_oe_o && acc_wr)); // R2
endmodule

// File: tb/tb_nibble_row_ram.sv
module tb_nibble_row_ram;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fetch_hi_i = 1'b0, fetch_lo_i = 1'b0, exec_i = 1'b0;
  logic [3:0] bus_i = '0;
  logic [3:0] bus_o;
  logic       bus_oe_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nibble_row_ram dut (
    .clk_i(clk), .rst_ni, .fetch_hi_i, .fetch_lo_i, .exec_i,
    .bus_i, .bus_o, .bus_oe_o
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // fetch phases; oe must stay low in both (R3)
  task automatic fetch(input logic [3:0] opc, input logic [3:0] opr);
    @(negedge clk); fetch_hi_i = 1; bus_i = opc;
    #2 chk("R3 fetch_hi oe", {7'd0, bus_oe_o}, 8'd0);
    @(negedge clk); fetch_hi_i = 0; fetch_lo_i = 1; bus_i = opr;
    #2 chk("R3 fetch_lo oe", {7'd0, bus_oe_o}, 8'd0);
    @(negedge clk); fetch_lo_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); exec_i = 0; bus_i = 4'h0;
    end
  endtask

  task automatic do_sel(input int row, input int lane);
    logic [4:0] r;
    logic [1:0] l;
    r = row[4:0]; l = lane[1:0];
    fetch(4'h2, 4'h0);
    exec_i = 1; bus_i = {1'b0, l, r[4]};
    @(negedge clk); bus_i = r[3:0];
    @(negedge clk); exec_i = 0;
  endtask

  task automatic do_write(input logic [3:0] v, input logic [3:0] opr);
    fetch(4'hE, opr);
    exec_i = 1; bus_i = v;
    #2 chk("R3 write no drive", {7'd0, bus_oe_o}, 8'd0);
    @(negedge clk); exec_i = 0;
  endtask

  task automatic do_read(input string req, input logic [3:0] exp);
    fetch(4'hE, 4'h9);
    exec_i = 1; bus_i = 4'h0;
    #2 chk({req, " oe"}, {7'd0, bus_oe_o}, 8'd1);
    chk({req, " data"}, {4'd0, bus_o}, {4'd0, exp});
    @(negedge clk); exec_i = 0;
    #2 chk("R3 oe after exec", {7'd0, bus_oe_o}, 8'd0);
  endtask

  task automatic t_reset;
    #2 chk("R1 oe in reset", {7'd0, bus_oe_o}, 8'd0);
    @(negedge clk); rst_ni = 1;
    idle(2);
    #2 chk("R1 oe after reset", {7'd0, bus_oe_o}, 8'd0);
    do_write(4'h5, 4'h0);          // no select yet: row 0 lane 0
    do_read("R1 R2 default row0 lane0", 4'h5);
    do_sel(0, 1);
    do_write(4'h6, 4'h3);          // operand bit3=0 -> write (R2)
    do_sel(0, 0);
    do_read("R2 lane0 after lane1 write", 4'h5);
  endtask

  task automatic t_merge;
    do_sel(3, 0); do_write(4'h1, 4'h0);
    do_sel(3, 1); do_write(4'h2, 4'h0);
    do_sel(3, 2); do_write(4'hA, 4'h0);
    do_sel(3, 3); do_write(4'h4, 4'h0);
    do_sel(3, 2); do_write(4'hC, 4'h0);
    do_sel(3, 0); do_read("R4 lane0 kept", 4'h1);
    do_sel(3, 1); do_read("R4 lane1 kept", 4'h2);
    do_sel(3, 2); do_read("R4 lane2 replaced", 4'hC);
    do_sel(3, 3); do_read("R4 lane3 kept", 4'h4);
    do_read("R5 selection held", 4'h4);
  endtask

  task automatic t_rows;
    do_sel(19, 1); do_write(4'h7, 4'h0);
    do_sel(16, 1); do_write(4'hB, 4'h0);
    do_sel(19, 1); do_read("R9 row19 independent", 4'h7);
    do_sel(3, 1);  do_read("R9 row3 untouched", 4'h2);
    do_sel(0, 1);  do_read("R9 row0 untouched", 4'h6);
  endtask

  task automatic t_range;
    do_sel(19, 1);
    do_sel(25, 3);                 // out of range: ignored
    do_write(4'h8, 4'h0);
    do_sel(19, 1); do_read("R6 stayed on row19 lane1", 4'h8);
    do_sel(19, 3); do_read("R6 lane3 untouched", 4'h0 ^ dummy_r19l3);
  endtask

  logic [3:0] dummy_r19l3;

  task automatic t_other;
    do_sel(3, 2);
    fetch(4'h7, 4'hF);
    exec_i = 1; bus_i = 4'h3;
    #2 chk("R7 other opcode no drive", {7'd0, bus_oe_o}, 8'd0);
    @(negedge clk); exec_i = 0;
    do_read("R7 data unchanged", 4'hC);
  endtask

  task automatic t_refresh;
    idle(150);
    do_sel(3, 3);  do_read("R8 row3 after idle", 4'h4);
    do_sel(19, 1); do_read("R8 row19 after idle", 4'h8);
    do_sel(0, 0);  do_read("R8 row0 after idle", 4'h5);
  endtask

  initial begin
    dummy_r19l3 = 4'h0;
    t_reset;
    t_merge;
    // give row19 lane3 a known value before the range test
    do_sel(19, 3); do_write(4'h9, 4'h0); dummy_r19l3 = 4'h9;
    t_rows;
    t_range;
    t_other;
    t_refresh;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule